// File: doc/BRIEF.md
# Staggered-Interval Pulse Canceller for Moving Target Indication

This block suppresses stationary clutter in a radar receive chain. Samples of each pulse arrive in range order. For every range bin the block combines the current sample with the same bin of earlier pulses and passes out the difference. Stationary returns cancel and moving returns remain. A run-time mode picks between a single-delay canceller (current minus previous pulse) and a double-delay canceller (current, twice the previous, and the pulse before that, with weights +1, -2, +1). Earlier pulses are held in two cascaded on-chip delay memories that are addressed by range bin.

The pulse repetition interval may be staggered, so the number of range bins differs from pulse to pulse. A small controller walks a short stagger table of per-pulse bin counts in a cycle. It restarts the range address at every start-of-pulse marker and flags a result valid only where every pulse taking part actually holds that bin. Each sample may carry one lane (real data) or several lanes (I and Q), and every lane is filtered alike. The output is widened so that no result can overflow.

Top module: `mti_canceller`

## Requirements
- R1: In two-pulse mode (mode_i = 0 at the start of the pulse), each lane of a valid output equals the current sample minus the same range bin of the previous pulse, as a signed two's-complement value.
- R2: In three-pulse mode (mode_i = 1 at the start of the pulse), each lane of a valid output equals current − 2 × previous + second-previous pulse at the same range bin.
- R3: Each output lane is DW+2 bits signed, so full-scale inputs of either sign give exact results in both modes. In two-pulse mode the two top bits of a valid lane are equal.
- R4: out_valid_o rises in the cycle after an accepted sample whose result is valid, and it stays low in any cycle that follows a cycle without in_valid_i.
- R5: After reset, and after any pulse start whose mode differs from the mode of the pulse before it, no output is valid until 1 (two-pulse mode) or 2 (three-pulse mode) complete pulses have been stored in that mode.
- R6: A pulse holds at most as many range bins as the stagger entry in use, clamped to MAX_BINS. Entry g sits at bits [g*LW +: LW] of stag_tab_i. The first pulse after reset uses entry 0, and each later pulse start moves to the next entry, wrapping to 0 after the entry stag_last_i. Samples past that count give no output and are not stored.
- R7: A range bin gives a valid output only if it is present in every pulse it is compared with. These are the previous pulse, and in three-pulse mode also the one before it.
- R8: A sample with in_valid_i and sop_i both high is range bin 0 of a new pulse. The mode is sampled only there, so a change of mode_i within a pulse has no effect on that pulse.
- R9: Samples that arrive before the first start-of-pulse after reset are ignored.
- R10: During and right after reset, out_valid_o is 0 and out_data_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Sample present this cycle |
| sop_i | input | 1 | With in_valid_i: first range bin of a new pulse |
| mode_i | input | 1 | 0 = two-pulse, 1 = three-pulse; sampled at pulse start |
| in_data_i | input | LANES*DW | Signed sample lanes, lane l at [l*DW +: DW] |
| stag_tab_i | input | STAG_N*LW | Stagger table of bin counts per pulse |
| stag_last_i | input | SW | Index of the last table entry used in the cycle |
| out_valid_o | output | 1 | Filtered result valid |
| out_data_o | output | LANES*(DW+2) | Signed result lanes, lane l at [l*(DW+2) +: DW+2] |

## Verification
Every filtered result is due exactly one clock edge after the edge that accepts its sample, since only the output register lies between them. The bench drives each sample away from the edge and reads the output 1 ns after the next rising edge. It then compares the result with a pulse-history model that is updated for that same sample. Idle cycles are checked at the same point for a low valid. Because of this, a result that comes early, comes late or is dropped by a gap shows up as a mismatch in either valid or data.

// File: rtl/mti_pkg.sv
package mti_pkg;
   typedef enum logic {
      CANC_TWO   = 1'b0,
      CANC_THREE = 1'b1
   } canc_mode_e;

   localparam int HIST_STAGES = 2;
endpackage

// File: rtl/mti_delay_line.sv
module mti_delay_line #(
   parameter int W     = 24,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [W-1:0]  din_i,
   output logic [W-1:0]  dout_o
);
   logic [W-1:0] store [DEPTH];

   // read returns the value held before this cycle's write
   assign dout_o = store[addr_i];

   always_ff @(posedge clk_i) begin
      if (we_i) store[addr_i] <= din_i;
   end
endmodule

// File: rtl/mti_lane_diff.sv
module mti_lane_diff #(
   parameter int DW  = 12,
   localparam int OW = DW + 2
) (
   input  logic [DW-1:0] cur_i,
   input  logic [DW-1:0] prev1_i,
   input  logic [DW-1:0] prev2_i,
   input  logic          three_i,
   output logic [OW-1:0] res_o
);
   logic signed [OW-1:0] xs, as, bs;

   always_comb begin
      xs = $signed({{2{cur_i[DW-1]}},   cur_i});
      as = $signed({{2{prev1_i[DW-1]}}, prev1_i});
      bs = $signed({{2{prev2_i[DW-1]}}, prev2_i});
      if (three_i) res_o = xs - (as <<< 1) + bs;
      else         res_o = xs - as;
   end
endmodule

// File: rtl/mti_stagger_ctrl.sv
module mti_stagger_ctrl #(
   parameter int MAX_BINS = 32,
   parameter int STAG_N   = 4,
   localparam int AW      = $clog2(MAX_BINS),
   localparam int LW      = $clog2(MAX_BINS + 1),
   localparam int SW      = (STAG_N > 1) ? $clog2(STAG_N) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               in_valid_i,
   input  logic               sop_i,
   input  logic               mode_i,
   input  logic [STAG_N*LW-1:0] stag_tab_i,
   input  logic [SW-1:0]      stag_last_i,
   output logic               wr_en_o,
   output logic [AW-1:0]      addr_o,
   output logic               mode_o,
   output logic               ok_o,
   output logic               mode_act_o
);
   logic [LW-1:0] tab [STAG_N];
   for (genvar g = 0; g < STAG_N; g++) begin : g_tab
      assign tab[g] = stag_tab_i[g*LW +: LW];
   end

   logic          started_q, mode_q;
   logic [SW-1:0] ptr_q;
   logic [LW-1:0] lim_q, pos_q, len1_q, len2_q;
   logic [1:0]    fill_q;

   logic          start_c, live_c, acc_c;
   logic [SW-1:0] last_c, ptr_nx;
   logic [LW-1:0] entry_c, newlim_c, bin_c, lim_c, p1_c, p2_c;
   logic [1:0]    fill_c;
   logic          mode_c, ok_c;

   always_comb begin
      start_c  = in_valid_i & sop_i;
      last_c   = (stag_last_i > SW'(STAG_N - 1)) ? SW'(STAG_N - 1) : stag_last_i;
      ptr_nx   = (ptr_q >= last_c) ? '0 : ptr_q + SW'(1);
      entry_c  = tab[ptr_q];
      newlim_c = (entry_c > LW'(MAX_BINS)) ? LW'(MAX_BINS) : entry_c;
      bin_c    = start_c ? '0 : pos_q;
      lim_c    = start_c ? newlim_c : lim_q;
      live_c   = started_q | start_c;
      acc_c    = in_valid_i & live_c & (bin_c < lim_c);
      p1_c     = start_c ? pos_q  : len1_q;
      p2_c     = start_c ? len1_q : len2_q;
      mode_c   = start_c ? mode_i : mode_q;
      if (!start_c)                          fill_c = fill_q;
      else if (!started_q || mode_i != mode_q) fill_c = 2'd0;
      else if (fill_q == 2'd2)               fill_c = 2'd2;
      else                                   fill_c = fill_q + 2'd1;
      if (mode_c == mti_pkg::CANC_THREE)
         ok_c = acc_c & (fill_c == 2'd2) & (bin_c < p1_c) & (bin_c < p2_c);
      else
         ok_c = acc_c & (fill_c != 2'd0) & (bin_c < p1_c);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         started_q <= 1'b0;
         mode_q    <= 1'b0;
         ptr_q     <= '0;
         lim_q     <= '0;
         pos_q     <= '0;
         len1_q    <= '0;
         len2_q    <= '0;
         fill_q    <= '0;
      end else if (start_c) begin
         started_q <= 1'b1;
         mode_q    <= mode_i;
         ptr_q     <= ptr_nx;
         lim_q     <= newlim_c;
         fill_q    <= fill_c;
         len1_q    <= pos_q;
         len2_q    <= len1_q;
         pos_q     <= acc_c ? LW'(1) : '0;
      end else if (acc_c) begin
         pos_q     <= pos_q + LW'(1);
      end
   end

   assign wr_en_o    = acc_c;
   assign addr_o     = bin_c[AW-1:0];
   assign mode_o     = mode_c;
   assign ok_o       = ok_c;
   assign mode_act_o = mode_q;

   // R8: within a pulse, consecutive writes go to consecutive range bins
   a_r8_addr_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_o && !start_c && $past(wr_en_o)) |-> (addr_o == $past(addr_o) + AW'(1)));
endmodule

// File: rtl/mti_canceller.sv
module mti_canceller #(
   parameter int DW       = 12,
   parameter int LANES    = 2,
   parameter int MAX_BINS = 32,
   parameter int STAG_N   = 4,
   localparam int OW      = DW + 2,
   localparam int AW      = $clog2(MAX_BINS),
   localparam int LW      = $clog2(MAX_BINS + 1),
   localparam int SW      = (STAG_N > 1) ? $clog2(STAG_N) : 1,
   localparam int SAMP_W  = LANES * DW
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  in_valid_i,
   input  logic                  sop_i,
   input  logic                  mode_i,
   input  logic [SAMP_W-1:0]     in_data_i,
   input  logic [STAG_N*LW-1:0]  stag_tab_i,
   input  logic [SW-1:0]         stag_last_i,
   output logic                  out_valid_o,
   output logic [LANES*OW-1:0]   out_data_o
);
   if (DW < 2) begin : g_bad_dw
      $error("mti_canceller: DW must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("mti_canceller: LANES must be at least 1");
   end
   if (MAX_BINS < 2) begin : g_bad_bins
      $error("mti_canceller: MAX_BINS must be at least 2");
   end
   if (STAG_N < 1) begin : g_bad_stag
      $error("mti_canceller: STAG_N must be at least 1");
   end

   logic          wr_en, mode_e, ok, mode_act;
   logic [AW-1:0] addr;

   mti_stagger_ctrl #(.MAX_BINS(MAX_BINS), .STAG_N(STAG_N)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_valid_i (in_valid_i),
      .sop_i      (sop_i),
      .mode_i     (mode_i),
      .stag_tab_i (stag_tab_i),
      .stag_last_i(stag_last_i),
      .wr_en_o    (wr_en),
      .addr_o     (addr),
      .mode_o     (mode_e),
      .ok_o       (ok),
      .mode_act_o (mode_act)
   );

   // tap[0] is the live sample, tap[s] the same bin s pulses back
   logic [SAMP_W-1:0] tap [mti_pkg::HIST_STAGES + 1];
   assign tap[0] = in_data_i;

   for (genvar s = 0; s < mti_pkg::HIST_STAGES; s++) begin : g_hist
      mti_delay_line #(.W(SAMP_W), .DEPTH(MAX_BINS)) u_dl (
         .clk_i  (clk_i),
         .we_i   (wr_en),
         .addr_i (addr),
         .din_i  (tap[s]),
         .dout_o (tap[s+1])
      );
   end

   logic [LANES*OW-1:0] res_flat;
   logic                out_mode_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      mti_lane_diff #(.DW(DW)) u_diff (
         .cur_i   (tap[0][l*DW +: DW]),
         .prev1_i (tap[1][l*DW +: DW]),
         .prev2_i (tap[2][l*DW +: DW]),
         .three_i (mode_e),
         .res_o   (res_flat[l*OW +: OW])
      );

      // R3: a two-pulse result needs only DW+1 bits
      a_r3_two_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (out_valid_o && !out_mode_q) |-> (out_data_o[l*OW + OW - 1] == out_data_o[l*OW + OW - 2]));
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         out_data_o  <= '0;
         out_mode_q  <= 1'b0;
      end else begin
         out_valid_o <= ok;
         out_data_o  <= ok ? res_flat : '0;
         out_mode_q  <= mode_e;
      end
   end

   // R4: a valid result always traces back to a sample one cycle earlier
   a_r4_valid_needs_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> $past(in_valid_i));

   // R5: a pulse that opens with a new mode never yields a result
   a_r5_no_valid_after_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && sop_i && (mode_i != mode_act)) |=> !out_valid_o);
endmodule

// File: tb/tb_mti_canceller.sv
module tb_mti_canceller;
   localparam int DW = 12, LANES = 2, MAXB = 32, STN = 4;
   localparam int LW = 6, SW = 2, OW = DW + 2;
   localparam int VMAX = 2047, VMIN = -2048;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, sop = 1'b0, mode = 1'b0;
   logic [LANES*DW-1:0] in_data = '0;
   logic [STN*LW-1:0]   stag_tab = '0;
   logic [SW-1:0]       stag_last = '0;
   logic                out_valid;
   logic [LANES*OW-1:0] out_data;

   always #4 clk = ~clk;

   mti_canceller #(.DW(DW), .LANES(LANES), .MAX_BINS(MAXB), .STAG_N(STN)) dut (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .sop_i(sop), .mode_i(mode),
      .in_data_i(in_data), .stag_tab_i(stag_tab), .stag_last_i(stag_last),
      .out_valid_o(out_valid), .out_data_o(out_data));

   int checks = 0, errors = 0;

   // pulse-history model
   int  h1 [LANES][MAXB], h2 [LANES][MAXB], cur [LANES][MAXB];
   int  l1 = 0, l2 = 0, cnt = 0, lim = 0, ptr = 0, fill = 0, pulse_no = 0;
   bit  started = 0, mq = 0;
   int  tab_m [STN];
   int  last_m = 0;

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic set_table(int e0, int e1, int e2, int e3, int last);
      tab_m[0] = e0; tab_m[1] = e1; tab_m[2] = e2; tab_m[3] = e3;
      last_m = last;
      stag_tab  = {LW'(e3), LW'(e2), LW'(e1), LW'(e0)};
      stag_last = SW'(last);
   endtask

   function automatic int next_lim();
      return (tab_m[ptr] > MAXB) ? MAXB : tab_m[ptr];
   endfunction

   function automatic int rnd_val();
      return int'($urandom_range(0, 4095)) - 2048;
   endfunction

   task automatic sample(bit s, int xa, int xb, string dtag);
      int  k, ex [LANES], x [LANES];
      bit  acc, ev, filled;
      string vtag;
      x[0] = xa; x[1] = xb;
      if (s) begin
         if (started) fill = (mode != mq) ? 0 : ((fill == 2) ? 2 : fill + 1);
         else         fill = 0;
         l2 = l1; l1 = cnt; h2 = h1; h1 = cur;
         lim = next_lim();
         ptr = (ptr >= ((last_m > STN - 1) ? STN - 1 : last_m)) ? 0 : ptr + 1;
         mq = mode; started = 1; cnt = 0; pulse_no++;
      end
      k = cnt;
      acc = started && (k < lim);
      filled = mq ? (fill == 2) : (fill >= 1);
      ev = acc && filled && (k < l1) && (!mq || k < l2);
      if (!started)     vtag = "R9";
      else if (!acc)    vtag = "R6";
      else if (!filled) vtag = "R5";
      else if (!ev)     vtag = "R7";
      else              vtag = "R4";
      for (int l = 0; l < LANES; l++) ex[l] = 0;
      if (acc) begin
         for (int l = 0; l < LANES; l++) begin
            cur[l][k] = x[l];
            ex[l] = mq ? (x[l] - 2 * h1[l][k] + h2[l][k]) : (x[l] - h1[l][k]);
         end
         cnt++;
      end
      in_valid = 1'b1; sop = s;
      in_data  = {DW'(xb), DW'(xa)};
      @(posedge clk); #1;
      in_valid = 1'b0; sop = 1'b0;
      chk(out_valid == ev, vtag, "out_valid", int'(out_valid), int'(ev));
      if (ev && out_valid) begin
         for (int l = 0; l < LANES; l++)
            chk($signed(out_data[l*OW +: OW]) == ex[l], dtag, "lane result",
                int'($signed(out_data[l*OW +: OW])), ex[l]);
      end
   endtask

   task automatic idle();
      in_valid = 1'b0;
      @(posedge clk); #1;
      chk(out_valid == 1'b0, "R4", "out_valid idle", int'(out_valid), 0);
   endtask

   // kind 0: random data; kind 1: full-scale, sign alternating per pulse
   task automatic send_pulse(bit md, int kind, int flip_at, bit gaps);
      int n, xa, xb;
      string dtag;
      n = next_lim() + int'($urandom_range(0, 6)) - 3;
      if (n < 1) n = 1;
      dtag = (flip_at >= 0) ? "R8" : (kind == 1) ? "R3" : (md ? "R2" : "R1");
      mode = md;
      for (int i = 0; i < n; i++) begin
         if (i == flip_at) mode = ~md;
         if (kind == 1) begin
            xa = (pulse_no % 2 == 1) ? VMAX : VMIN;
            xb = (pulse_no % 2 == 1) ? VMIN : VMAX;
            if (i == 0) begin
               xa = (pulse_no % 2 == 0) ? VMAX : VMIN;
               xb = (pulse_no % 2 == 0) ? VMIN : VMAX;
            end
         end else begin
            xa = rnd_val(); xb = rnd_val();
         end
         sample(i == 0, xa, xb, dtag);
         if (gaps && ($urandom_range(0, 3) == 0)) idle();
      end
      mode = md;
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit md;
      void'($urandom(32'd5150));
      for (int l = 0; l < LANES; l++)
         for (int b = 0; b < MAXB; b++) begin
            cur[l][b] = 0; h1[l][b] = 0; h2[l][b] = 0;
         end
      set_table(20, 40, 12, 27, 3);  // entry 1 clamps to 32 (R6)
      repeat (3) @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
      chk(out_data == '0, "R10", "out_data in reset", int'(out_data[OW-1:0]), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
      // R9: samples before any pulse start
      for (int i = 0; i < 3; i++) sample(1'b0, rnd_val(), rnd_val(), "R9");
      // R1, R6, R7: two-pulse with staggered lengths
      for (int p = 0; p < 6; p++) send_pulse(1'b0, 0, -1, 1'b1);
      // R2, R5: switch to three-pulse
      for (int p = 0; p < 6; p++) send_pulse(1'b1, 0, -1, 1'b1);
      // R3: full-scale extremes in both modes
      for (int p = 0; p < 3; p++) send_pulse(1'b0, 1, -1, 1'b0);
      for (int p = 0; p < 4; p++) send_pulse(1'b1, 1, -1, 1'b0);
      // R8: mode toggled inside a pulse has no effect
      send_pulse(1'b1, 0, 5, 1'b0);
      send_pulse(1'b1, 0, 3, 1'b1);
      // R6: shorter stagger cycle
      set_table(9, 16, 30, 5, 1);
      for (int p = 0; p < 6; p++) send_pulse(1'b0, 0, -1, 1'b1);
      // mixed random run
      set_table(32, 18, 25, 7, 2);
      md = 1'b1;
      for (int p = 0; p < 30; p++) begin
         if ($urandom_range(0, 4) == 0) md = ~md;
         send_pulse(md, ($urandom_range(0, 5) == 0) ? 1 : 0, -1, 1'b1);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule